// File: doc/BRIEF.md
# Serial Slave Hold Control

This block sits at the front of a serial flash slave port and decides when the port is paused. It samples an active-low select, an active-low hold input and the serial clock on a fast system clock, and finds edges on the sampled copies. A hold request pauses the port at once if the serial clock is low. If the serial clock is high, the pause is deferred to the next falling serial clock edge. Release follows the same rule.

Behind the hold logic sits a byte shift register. It captures the serial input on rising serial clock edges and drives the serial output on falling edges, most significant bit first. While the port is paused, the output is disabled and clock edges neither shift nor count. Raising the select line clears all interface state, including a pause in progress. A busy flag from the internal write engine passes through unchanged, because a pause never stops that engine.

Top module: `spi_hold_front`

## Requirements
- R1: With select low and the serial clock low, a falling hold input sets `paused` within SYNC+2 system clocks.
- R2: A falling hold input seen while the serial clock is high leaves `paused` low. The pause starts at the next falling serial clock edge, and that edge still advances the output bit.
- R3: A rising hold input while the serial clock is low clears `paused`. If the clock is high, the pause ends at the next falling serial clock edge, and that edge does not advance the output bit.
- R4: While `paused` is high, `so_oe` and `so` are 0. Rising serial clock edges capture nothing and do not count toward a byte, falling edges do not shift, and `rx_valid` stays low.
- R5: `busy_out` equals `busy_in` at all times, whether or not the port is paused.
- R6: While select is high, the bit counter, receive register, pause state and both deferred-edge flags are cleared, and the transmit register holds `tx_data`. After select falls again, byte assembly starts from bit 0.
- R7: If the hold input is already low when select falls, with the serial clock low, the port starts out paused.
- R8: Bits from `si` are captured on unpaused rising serial clock edges, the first bit becoming the MSB. After every 8th such edge, `rx_valid` is high for exactly one system clock and `rx_data` carries the byte.
- R9: `so` presents `tx_data` MSB first from the moment select falls. It moves to the next bit on each unpaused falling edge and reloads `tx_data` after 8 bits.
- R10: `so_oe` is 1 exactly when `tx_en` is 1, select is low and the port is not paused.
- R11: A hold edge that is reversed before the deferring falling serial clock edge arrives cancels the deferred change: the pause state stays as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Select, active low |
| hold_n | input | 1 | Hold request, active low |
| si | input | 1 | Serial data in |
| tx_data | input | BITS | Byte to transmit, loaded at select and at each byte boundary |
| tx_en | input | 1 | High during a transmit phase |
| busy_in | input | 1 | Busy flag from the internal write engine |
| so | output | 1 | Serial data out, 0 when not enabled |
| so_oe | output | 1 | Output enable for `so` (0 means high impedance) |
| rx_data | output | BITS | Last received byte |
| rx_valid | output | 1 | One-clock pulse when a byte is complete |
| paused | output | 1 | Hold is in effect |
| busy_out | output | 1 | Copy of `busy_in` |

## Verification
The bench builds the block with BITS=8 and SYNC=2. Each serial clock half-period is six system clocks, so every sampled edge settles well before the next one. These values let hold edges be placed in either clock phase and reversed within one phase. They also let select be dropped mid-pause and restarted, and let random traffic cover byte boundaries that fall across paused stretches.

// File: rtl/spi_hold_front.sv
module spi_hold_front #(
  parameter int BITS = 8,
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk,
  input  logic            cs_n,
  input  logic            hold_n,
  input  logic            si,
  input  logic [BITS-1:0] tx_data,
  input  logic            tx_en,
  input  logic            busy_in,
  output logic            so,
  output logic            so_oe,
  output logic [BITS-1:0] rx_data,
  output logic            rx_valid,
  output logic            paused,
  output logic            busy_out
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [SYNC-1:0] sclk_q, cs_q, hold_q, si_q;
  logic sclk_s, cs_s, hold_s, si_s;
  logic sclk_d, cs_d, hold_d;
  logic sclk_rise, sclk_fall, hold_fall, hold_rise, cs_fall;
  logic pend_in, pend_out;
  logic [CW-1:0] cnt;
  logic [BITS-1:0] rx_sh, tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      hold_q <= '1;
      si_q   <= '0;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      hold_d <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[SYNC-2:0], sclk};
      cs_q   <= {cs_q[SYNC-2:0], cs_n};
      hold_q <= {hold_q[SYNC-2:0], hold_n};
      si_q   <= {si_q[SYNC-2:0], si};
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      hold_d <= hold_s;
    end
  end

  assign sclk_s    = sclk_q[SYNC-1];
  assign cs_s      = cs_q[SYNC-1];
  assign hold_s    = hold_q[SYNC-1];
  assign si_s      = si_q[SYNC-1];
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign hold_fall = ~hold_s & hold_d;
  assign hold_rise = hold_s & ~hold_d;
  assign cs_fall   = ~cs_s & cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paused   <= 1'b0;
      pend_in  <= 1'b0;
      pend_out <= 1'b0;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (cs_s) begin
      paused   <= 1'b0;
      pend_in  <= 1'b0;
      pend_out <= 1'b0;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= tx_data;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sclk_rise && !paused) begin
        rx_sh <= {rx_sh[BITS-2:0], si_s};
        cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
        if (cnt == LAST) begin
          rx_valid <= 1'b1;
          rx_data  <= {rx_sh[BITS-2:0], si_s};
        end
      end
      if (sclk_fall && !paused)
        tx_sh <= (cnt == '0) ? tx_data : {tx_sh[BITS-2:0], 1'b0};

      if (cs_fall) begin
        if (!hold_s) begin
          if (!sclk_s) paused <= 1'b1;
          else         pend_in <= 1'b1;
        end
      end else if (hold_fall) begin
        pend_out <= 1'b0;
        if (!paused) begin
          if (!sclk_s) paused <= 1'b1;
          else         pend_in <= 1'b1;
        end
      end else if (hold_rise) begin
        pend_in <= 1'b0;
        if (paused) begin
          if (!sclk_s) paused <= 1'b0;
          else         pend_out <= 1'b1;
        end
      end else if (sclk_fall) begin
        if (pend_in)  paused <= 1'b1;
        if (pend_out) paused <= 1'b0;
        pend_in  <= 1'b0;
        pend_out <= 1'b0;
      end
    end
  end

  assign so_oe    = tx_en & ~cs_s & ~paused;
  assign so       = so_oe & tx_sh[BITS-1];
  assign busy_out = busy_in;
endmodule

// File: rtl/spi_hold_front_chk.sv
module spi_hold_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic cs_fall,
  input logic sclk_s,
  input logic hold_fall,
  input logic hold_rise,
  input logic paused,
  input logic so,
  input logic so_oe,
  input logic rx_valid
);
  p_enter_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !cs_fall && hold_fall && !sclk_s) |=> paused);

  p_defer_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !cs_fall && hold_fall && sclk_s && !paused) |=> !paused);

  p_exit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !cs_fall && hold_rise && !sclk_s && paused) |=> !paused);

  p_defer_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !cs_fall && hold_rise && sclk_s && paused) |=> paused);

  p_quiet_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    paused |-> (!so_oe && !so));

  p_no_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    paused |=> !rx_valid);

  p_cs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !paused);

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind spi_hold_front spi_hold_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall), .sclk_s(sclk_s),
  .hold_fall(hold_fall), .hold_rise(hold_rise), .paused(paused),
  .so(so), .so_oe(so_oe), .rx_valid(rx_valid)
);

// File: tb/tb_spi_hold_front.sv
module tb_spi_hold_front;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, hold_n = 1, si = 0;
  logic [7:0] tx_data = 8'hA5;
  logic tx_en = 1, busy_in = 0;
  logic so, so_oe, rx_valid, paused, busy_out;
  logic [7:0] rx_data;

  spi_hold_front dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  logic m_held, m_pin, m_pout;
  int   m_nrx, m_nsh;
  logic [7:0] m_rx;
  logic [7:0] exp_b [0:255];
  logic [7:0] got_b [0:255];
  int exp_n, got_n;

  always @(negedge clk)
    if (rx_valid && got_n < 256) begin
      got_b[got_n] = rx_data;
      got_n++;
    end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_so(input logic [7:0] d, input int n);
    return d[7 - (n % 8)];
  endfunction

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic model_clear();
    m_held = 0; m_pin = 0; m_pout = 0;
    m_nrx = 0; m_nsh = 0; m_rx = 0;
  endtask

  task automatic low_check();
    chk("R10 so_oe", so_oe, tx_en && !m_held);
    if (tx_en && !m_held) chk("R9 so bit", so, exp_so(tx_data, m_nsh));
    else chk("R4 so quiet", so, 0);
  endtask

  task automatic do_rise();
    if (!m_held) begin
      m_rx = {m_rx[6:0], si};
      m_nrx++;
      if (m_nrx % 8 == 0 && exp_n < 256) begin
        exp_b[exp_n] = m_rx;
        exp_n++;
      end
    end
    sclk = 1;
    wait_half();
  endtask

  task automatic do_fall();
    if (!m_held) m_nsh++;
    if (m_pin)  m_held = 1;
    if (m_pout) m_held = 0;
    m_pin = 0; m_pout = 0;
    sclk = 0;
    wait_half();
    chk("R3 paused after fall", paused, m_held);
  endtask

  task automatic do_hold(input logic v);
    hold_n = v;
    if (!v) begin
      m_pout = 0;
      if (!m_held) begin
        if (!sclk) m_held = 1;
        else m_pin = 1;
      end
    end else begin
      m_pin = 0;
      if (m_held) begin
        if (!sclk) m_held = 0;
        else m_pout = 1;
      end
    end
    wait_half();
    chk("R1 paused after hold edge", paused, m_held);
  endtask

  task automatic cs_low();
    model_clear();
    cs_n = 0;
    if (!hold_n) m_held = 1;
    exp_n = 0; got_n = 0;
    wait_half();
  endtask

  task automatic cs_high();
    cs_n = 1;
    wait_half();
    chk("R6 paused cleared", paused, 0);
    chk("R6 oe off", so_oe, 0);
  endtask

  task automatic compare_bytes();
    chk("R8 byte count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      chk("R8 byte value", got_b[i], exp_b[i]);
  endtask

  task automatic pulse(input logic b);
    si = b;
    wait_half();
    low_check();
    do_rise();
    do_fall();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_clear();
    exp_n = 0; got_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    wait_half();
    chk("R6 reset paused", paused, 0);
    chk("R10 reset oe", so_oe, 0);
    chk("R8 reset valid", rx_valid, 0);

    // plain byte, R8 and R9
    tx_data = 8'h3C;
    cs_low();
    for (int i = 0; i < 8; i++) pulse(1'((8'hC5 >> (7 - i)) & 1));
    for (int i = 0; i < 8; i++) pulse(1'((8'h81 >> (7 - i)) & 1));
    compare_bytes();
    chk("R8 first byte", got_b[0], 8'hC5);
    cs_high();

    // R2 deferred entry, R3 deferred exit, R5 busy passthrough
    cs_low();
    pulse(1); pulse(0);
    si = 1; wait_half(); do_rise();
    do_hold(0);
    chk("R2 not yet paused", paused, 0);
    do_fall();
    chk("R2 paused at fall", paused, 1);
    busy_in = 1; #1;
    chk("R5 busy while paused", busy_out, 1);
    busy_in = 0; #1;
    chk("R5 busy low", busy_out, 0);
    pulse(0); pulse(1);
    si = 0; wait_half(); do_rise();
    do_hold(1);
    chk("R3 still paused", paused, 1);
    do_fall();
    chk("R3 released at fall", paused, 0);
    for (int i = 0; i < 5; i++) pulse(1'(i));
    compare_bytes();
    cs_high();

    // R11 cancelled pending entry
    cs_low();
    pulse(1);
    si = 0; wait_half(); do_rise();
    do_hold(0); do_hold(1);
    do_fall();
    chk("R11 cancel keeps running", paused, 0);
    for (int i = 0; i < 6; i++) pulse(1);
    compare_bytes();
    cs_high();

    // R6 select rise during pause, then R7 start paused
    cs_low();
    pulse(1); pulse(1); pulse(0);
    do_hold(0);
    cs_high();
    cs_low();
    chk("R7 starts paused", paused, 1);
    low_check();
    pulse(1);
    do_hold(1);
    for (int i = 0; i < 8; i++) pulse(1'((8'h96 >> (7 - i)) & 1));
    compare_bytes();
    chk("R6 fresh byte", got_b[0], 8'h96);
    cs_high();

    // random sessions
    for (int s = 0; s < 20; s++) begin
      tx_data = 8'($urandom);
      tx_en = ($urandom % 4) != 0;
      cs_low();
      for (int k = 0; k < 60; k++) begin
        int op;
        op = int'($urandom % 4);
        if (op < 2) begin
          si = 1'($urandom);
          wait_half();
          low_check();
          do_rise();
          if ($urandom % 3 == 0) do_hold(!hold_n);
          if ($urandom % 5 == 0) do_hold(!hold_n);
          do_fall();
        end else if (op == 2) begin
          do_hold(!hold_n);
        end else begin
          wait_half();
          low_check();
        end
      end
      compare_bytes();
      hold_n = 1;
      cs_high();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule